// File: doc/BRIEF.md
# Bus Condition Sequencer for a Two-Wire Serial Master

This block sits between a two-wire serial master's shift logic and its clock and data pad drivers. A mode select input chooses who drives the two lines. With the select low, the shifter's clock and data pass straight through, and an edge detector on the sampled bus lines raises an interrupt when a start or stop condition appears. With the select high, a small sequencer owns the lines. It produces start, repeated start and stop conditions when software asks for one through three request bits. When a condition is complete it raises the interrupt.

Timing comes from a count-source enable. Each phase of a sequence lasts a parameterised number of enabled cycles (six by default). The data edge that forms a condition therefore has at least that many counts of clock-high before it and after it. When a condition has been produced, its request bit clears itself. The lines then stay at the levels the condition left behind until the next request arrives.

Top module: `i2c_cond_gen`

## Requirements
- R1: While `selGen` is 0, `sclOut` equals `shiftScl` and `sdaOut` equals `shiftSda`. No sequence runs, and pending request bits stay set.
- R2: After reset, with `selGen` at 1 and no request pending, both `sclOut` and `sdaOut` are 1.
- R3: A one-cycle pulse on `setReq` sets the matching bit of `reqBits` at the next edge. Bit 0 is start, bit 1 is repeated start and bit 2 is stop. A sequence enters its first phase at the first edge at which the generator is idle, `selGen` is 1 and a bit is pending.
- R4: A start condition drives (scl,sda) = (1,1), then (1,0), and ends at (0,0).
- R5: A repeated start drives (0,1), then (1,1), then (1,0), and ends at (0,0).
- R6: A stop drives (0,0), then (1,0), then (1,1), and ends at (1,1). No data edge happens while scl is low during any sequence.
- R7: Each phase lasts exactly HOLD_TICKS cycles with `tickEn` high. Cycles with `tickEn` low do not advance a phase.
- R8: In the cycle in which the end levels appear, `irq` is 1 for exactly one cycle and the served request bit is 0.
- R9: When several requests are pending, start is served first, then repeated start, then stop.
- R10: While `selGen` is 0, `irq` pulses for one cycle, one edge after `sdaIn` changes while `sclIn` is 1 in both the old and the new sample. A data change while the clock is low gives no pulse.
- R11: While `selGen` is 1, bus edges on `sclIn`/`sdaIn` do not raise `irq`.
- R12: After a condition completes, the outputs keep its end levels until another request is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count-source enable; one phase count per high cycle |
| selGen | input | 1 | 0: shifter drives lines; 1: sequencer drives lines |
| setReq | input | 3 | Request set pulses: bit0 start, bit1 repeated start, bit2 stop |
| shiftScl | input | 1 | Shifter clock output |
| shiftSda | input | 1 | Shifter data output |
| sclIn | input | 1 | Sampled bus clock level for detection |
| sdaIn | input | 1 | Sampled bus data level for detection |
| sclOut | output | 1 | Clock line drive (1 = released) |
| sdaOut | output | 1 | Data line drive (1 = released) |
| irq | output | 1 | Completion (select high) or detection (select low) pulse |
| reqBits | output | 3 | Pending request bits, same bit order as setReq |

## Verification
The bench sweeps every condition type over three count-source rates. It measures how many cycles each line level pair lasts, so a sequencer that starts a cycle late shows up as a stretched first phase, and one that counts raw clocks instead of enabled cycles shows up as phases that are too short. It checks that the interrupt coincides with the end levels and that the request bit has cleared by then; a design that clears late or pulses twice fails there. It leaves all three requests pending with the select low, then serves them in turn to catch a wrong priority order or a sequencer that ran in pass-through mode. Separate probes drive data edges while the clock is high and while it is low, in both modes, to catch a detector that ignores the clock level or stays active in generator mode.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_A    = 2'd1,
    PH_B    = 2'd2,
    PH_C    = 2'd3
  } phase_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic       cntClr;
    logic       cntRun;
    phase_e     phase;
    logic [2:0] kindOh;  // bit0 start, bit1 repeated start, bit2 stop
    logic       finish;
  } gen_strobe_t;
endpackage

// File: rtl/i2c_cond_dp.sv
module i2c_cond_dp
  import i2c_cond_pkg::*;
#(
  parameter int HOLD_TICKS = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic        selGen,
  input  logic        shiftScl,
  input  logic        shiftSda,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  gen_strobe_t ctl,
  output logic        phaseDone,
  output logic        detEvent,
  output logic        sclOut,
  output logic        sdaOut
);
  localparam int CW = (HOLD_TICKS > 2) ? $clog2(HOLD_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

  logic [CW-1:0] cnt;
  logic parkScl, parkSda;
  logic prevScl, prevSda;
  logic genScl, genSda;

  // phase tick counter
  always_ff @(posedge clk) begin
    if (!rstN)                   cnt <= '0;
    else if (ctl.cntClr)         cnt <= '0;
    else if (ctl.cntRun && tickEn) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign phaseDone = ctl.cntRun && tickEn && (cnt == LAST);

  // levels kept after a condition ends
  always_ff @(posedge clk) begin
    if (!rstN) begin
      parkScl <= 1'b1;
      parkSda <= 1'b1;
    end else if (ctl.finish) begin
      parkScl <= ctl.kindOh[2];
      parkSda <= ctl.kindOh[2];
    end
  end

  // level pair per phase and condition kind
  always_comb begin
    unique case (ctl.phase)
      PH_A:    begin genScl = 1'b0; genSda = ctl.kindOh[1];  end
      PH_B:    begin genScl = 1'b1; genSda = ~ctl.kindOh[2]; end
      PH_C:    begin genScl = 1'b1; genSda = ctl.kindOh[2];  end
      default: begin genScl = parkScl; genSda = parkSda;     end
    endcase
  end

  assign sclOut = selGen ? genScl : shiftScl;
  assign sdaOut = selGen ? genSda : shiftSda;

  // bus condition detector
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevScl <= 1'b1;
      prevSda <= 1'b1;
    end else begin
      prevScl <= sclIn;
      prevSda <= sdaIn;
    end
  end

  assign detEvent = prevScl && sclIn && (prevSda != sdaIn);

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= LAST);
  assert_cnt_gated_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && selGen) |=> $stable(cnt));
endmodule

// File: rtl/i2c_cond_ctrl.sv
module i2c_cond_ctrl
  import i2c_cond_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        selGen,
  input  logic [2:0]  setReq,
  input  logic        phaseDone,
  input  logic        detEvent,
  output gen_strobe_t ctl,
  output logic [2:0]  reqBits,
  output logic        irq,
  output logic        busy
);
  phase_e     phase;
  logic [2:0] kindOh;
  logic [2:0] pick;
  logic       goNow;
  logic       finish;

  assign pick   = reqBits & (~reqBits + 3'd1);  // lowest set bit wins
  assign goNow  = (phase == PH_IDLE) && selGen && (reqBits != 3'd0);
  assign finish = selGen && (phase == PH_C) && phaseDone;
  assign busy   = (phase != PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      kindOh <= 3'b001;
    end else if (!selGen) begin
      phase <= PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE: if (goNow) begin
          phase  <= pick[0] ? PH_B : PH_A;
          kindOh <= pick;
        end
        PH_A: if (phaseDone) phase <= PH_B;
        PH_B: if (phaseDone) phase <= PH_C;
        PH_C: if (phaseDone) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqBits <= 3'd0;
      irq     <= 1'b0;
    end else begin
      reqBits <= (reqBits & ~(finish ? kindOh : 3'd0)) | setReq;
      irq     <= selGen ? finish : detEvent;
    end
  end

  always_comb begin
    ctl.cntClr = goNow || !selGen;
    ctl.cntRun = busy && selGen;
    ctl.phase  = phase;
    ctl.kindOh = kindOh;
    ctl.finish = finish;
  end

  assert_no_seq_unselected_R1: assert property (@(posedge clk) disable iff (!rstN)
    !selGen |=> (phase == PH_IDLE));
  assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);
  assert_req_cleared_R8: assert property (@(posedge clk) disable iff (!rstN)
    (finish && ((setReq & kindOh) == 3'd0)) |=> ((reqBits & $past(kindOh)) == 3'd0));
  assert_priority_R9: assert property (@(posedge clk) disable iff (!rstN)
    goNow |=> ($onehot(kindOh) && (($past(reqBits) & kindOh) != 3'd0)
               && (($past(reqBits) & (kindOh - 3'd1)) == 3'd0)));
endmodule

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen
  import i2c_cond_pkg::*;
#(
  parameter int HOLD_TICKS = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       selGen,
  input  logic [2:0] setReq,
  input  logic       shiftScl,
  input  logic       shiftSda,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sclOut,
  output logic       sdaOut,
  output logic       irq,
  output logic [2:0] reqBits
);
  gen_strobe_t ctl;
  logic phaseDone, detEvent, busy;

  i2c_cond_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .selGen(selGen), .setReq(setReq),
    .phaseDone(phaseDone), .detEvent(detEvent), .ctl(ctl),
    .reqBits(reqBits), .irq(irq), .busy(busy)
  );

  i2c_cond_dp #(.HOLD_TICKS(HOLD_TICKS)) u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .selGen(selGen),
    .shiftScl(shiftScl), .shiftSda(shiftSda), .sclIn(sclIn), .sdaIn(sdaIn),
    .ctl(ctl), .phaseDone(phaseDone), .detEvent(detEvent),
    .sclOut(sclOut), .sdaOut(sdaOut)
  );

  // inside a running sequence, data only moves while the clock stays high
  assert_sda_edge_scl_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && selGen && $past(selGen) && (sdaOut != $past(sdaOut)))
      |-> (sclOut && $past(sclOut)));
endmodule

// File: tb/i2c_cond_gen_tb.sv
module i2c_cond_gen_tb;
  localparam int HOLD = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b1;
  logic selGen = 1'b0;
  logic [2:0] setReq = 3'd0;
  logic shiftScl = 1'b1, shiftSda = 1'b0, sclIn = 1'b1, sdaIn = 1'b1;
  logic sclOut, sdaOut, irq;
  logic [2:0] reqBits;

  int errors = 0;
  int checks = 0;
  int divider = 1;
  int tc = 0;

  always #2 clk = ~clk;

  i2c_cond_gen #(.HOLD_TICKS(HOLD)) u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .selGen(selGen), .setReq(setReq),
    .shiftScl(shiftScl), .shiftSda(shiftSda), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclOut(sclOut), .sdaOut(sdaOut), .irq(irq), .reqBits(reqBits)
  );

  always @(negedge clk) begin
    tc = tc + 1;
    tickEn = ((tc % divider) == 0);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] expLv(input int k, input int i);
    case (k)
      0:       return (i == 0) ? 2'b11 : 2'b10;
      1:       return (i == 0) ? 2'b01 : ((i == 1) ? 2'b11 : 2'b10);
      default: return (i == 0) ? 2'b00 : ((i == 1) ? 2'b10 : 2'b11);
    endcase
  endfunction

  task automatic runSeq(input int k, input int d);
    logic [1:0] lv [0:7];
    int ln [0:7];
    int nRun = 0;
    int guard = 0;
    int expN = (k == 0) ? 2 : 3;
    logic [1:0] endLv = (k == 2) ? 2'b11 : 2'b00;
    string tagK = (k == 0) ? "R4" : ((k == 1) ? "R5" : "R6");
    divider = d;
    repeat (d + 1) @(negedge clk);
    setReq = 3'(1 << k);
    @(negedge clk);
    setReq = 3'd0;
    chk(reqBits[k] == 1'b1, "R3 request latched", int'(reqBits), 1 << k);
    @(negedge clk);
    while (!irq && guard < 2000) begin
      if (nRun > 0 && {sclOut, sdaOut} == lv[nRun-1]) ln[nRun-1]++;
      else if (nRun < 8) begin
        lv[nRun] = {sclOut, sdaOut};
        ln[nRun] = 1;
        nRun++;
      end
      @(negedge clk);
      guard++;
    end
    chk(nRun == expN, {tagK, " phase count"}, nRun, expN);
    for (int i = 0; i < expN && i < nRun; i++) begin
      chk(lv[i] == expLv(k, i), {tagK, " phase levels"}, int'(lv[i]), int'(expLv(k, i)));
      if (i == 0) begin
        if (d == 1) chk(ln[0] == HOLD, "R3 first phase start", ln[0], HOLD);
        else chk(ln[0] >= (HOLD-1)*d + 1 && ln[0] <= HOLD*d, "R7 first phase length", ln[0], HOLD*d);
      end else begin
        chk(ln[i] == HOLD*d, "R7 phase length", ln[i], HOLD*d);
      end
    end
    chk(irq == 1'b1, "R8 completion irq", int'(irq), 1);
    chk({sclOut, sdaOut} == endLv, {tagK, " end levels"}, int'({sclOut, sdaOut}), int'(endLv));
    chk(reqBits[k] == 1'b0, "R8 request cleared", int'(reqBits), 0);
    @(negedge clk);
    chk(irq == 1'b0, "R8 irq single cycle", int'(irq), 0);
    repeat (20) @(negedge clk);
    chk({sclOut, sdaOut} == endLv, "R12 end levels held", int'({sclOut, sdaOut}), int'(endLv));
  endtask

  task automatic waitIrq(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (irq) begin seen = 1'b1; break; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit seen;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state, pass-through mode
    chk(reqBits == 3'd0, "R3 reset request bits", int'(reqBits), 0);
    chk(irq == 1'b0, "R8 reset irq", int'(irq), 0);
    chk({sclOut, sdaOut} == 2'b10, "R1 reset pass-through", int'({sclOut, sdaOut}), 2);
    for (int v = 0; v < 4; v++) begin
      shiftScl = v[1];
      shiftSda = v[0];
      @(negedge clk);
      chk({sclOut, sdaOut} == 2'(v), "R1 pass-through sweep", int'({sclOut, sdaOut}), v);
    end
    // detection in pass-through mode
    sdaIn = 1'b0;
    @(negedge clk);
    chk(irq == 1'b1, "R10 start detected", int'(irq), 1);
    @(negedge clk);
    chk(irq == 1'b0, "R10 detect pulse single", int'(irq), 0);
    sdaIn = 1'b1;
    @(negedge clk);
    chk(irq == 1'b1, "R10 stop detected", int'(irq), 1);
    sclIn = 1'b0;
    @(negedge clk);
    sdaIn = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0, "R10 data edge with clock low", int'(irq), 0);
    sclIn = 1'b1;
    @(negedge clk);
    chk(irq == 1'b0, "R10 clock edge only", int'(irq), 0);
    sdaIn = 1'b1;
    @(negedge clk);
    // generator mode idle
    selGen = 1'b1;
    @(negedge clk);
    chk({sclOut, sdaOut} == 2'b11, "R2 idle released", int'({sclOut, sdaOut}), 3);
    sdaIn = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0, "R11 start ignored", int'(irq), 0);
    sdaIn = 1'b1;
    @(negedge clk);
    chk(irq == 1'b0, "R11 stop ignored", int'(irq), 0);
    // all kinds over several count-source rates
    for (int d = 1; d <= 3; d++)
      for (int k = 0; k < 3; k++) runSeq(k, d);
    divider = 1;
    // pending requests held while unselected, then priority
    selGen = 1'b0;
    shiftScl = 1'b0;
    shiftSda = 1'b1;
    @(negedge clk);
    setReq = 3'b111;
    @(negedge clk);
    setReq = 3'd0;
    repeat (20) @(negedge clk);
    chk(reqBits == 3'b111, "R1 requests held unselected", int'(reqBits), 7);
    chk({sclOut, sdaOut} == 2'b01, "R1 no generation unselected", int'({sclOut, sdaOut}), 1);
    selGen = 1'b1;
    waitIrq(seen);
    chk(seen && reqBits == 3'b110, "R9 start served first", int'(reqBits), 6);
    waitIrq(seen);
    chk(seen && reqBits == 3'b100, "R9 repeated start second", int'(reqBits), 4);
    waitIrq(seen);
    chk(seen && reqBits == 3'b000, "R9 stop last", int'(reqBits), 0);
    chk({sclOut, sdaOut} == 2'b11, "R9 final stop levels", int'({sclOut, sdaOut}), 3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule